// File: doc/BRIEF.md
# Register-Programmed Request Traffic Generator

This block turns a small bank of 32-bit registers into a stream of request descriptors. It is meant for measuring link throughput. Software loads a 64-bit target address, a pattern word and a burst count. It then writes the control word with the doorbell bit set. The engine emits one descriptor per accepted handshake. Each descriptor carries an address, a length in dwords, a direction flag and a data word. A repeat flag in the burst-count register keeps the engine cycling through bursts until software clears the flag. The engine then stops at the end of the burst already under way.

Two 64-bit counters tally accepted descriptors, one for writes and one for reads. Software can freeze both counters. Both halves of a count can then be read without tearing, and a further write resumes counting. The descriptor port is valid/ready with no buffering. Once `req_valid` rises, every descriptor field holds steady until `req_ready` is seen high at a clock edge. The engine never withdraws a descriptor it has offered. A low `req_ready` stalls the engine indefinitely and loses nothing. The register port is a plain single-cycle write strobe with combinational read data.

Top module: `bus_traffic_gen`

## Requirements
- R1: After synchronous reset, `req_valid` is 0. The status, control, address, pattern, burst and scratch registers read 0. Both counters read 0. The count-control register reads 0x20 (counting enabled).
- R2: Registers sit at these byte offsets, and unmapped offsets read 0. Target address low 0x000 and high 0x004. Burst 0x008. Control 0x00C. Pattern 0x010. Status 0x014. Scratch registers 0x018 and 0x01C. Count control 0x058 (bit 5 enables counting). Write count low/high 0x100/0x104. Read count low/high 0x108/0x10C.
- R3: A control write with bit 0 set while idle starts a run, and `req_valid` is high in the cycle after that write. The first descriptor carries address {high,low}, length equal to control bits 13:2, and direction equal to control bit 1 (1 = write). Its data word equals the pattern register. Control bit 0 always reads back 0.
- R4: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and the address, data, length and direction are unchanged in the next cycle.
- R5: With control bit 16 set, the data word rises by 1 (mod 2^32) after each accepted descriptor. With it clear, every descriptor carries the pattern value.
- R6: With control bit 18 clear, the address rises by 4 times the length (64-bit carry) after each accepted descriptor. With it set, the address stays fixed.
- R7: With burst bit 31 clear, exactly N descriptors are issued, where N is burst bits 30:0. After the last accepted one, `req_valid` falls and status bit 0 (done) reads 1.
- R8: With burst bit 31 set, the engine reloads N at the end of each burst and keeps issuing descriptors without setting done. Address and data continue from where they were. Once the bit is cleared, the engine stops after the burst in progress.
- R9: A control-register write while a run is active is ignored entirely. The stored control value is unchanged and the running descriptor stream is undisturbed.
- R10: Writing 0 to status bit 0 clears done. Writing 1 leaves it unchanged.
- R11: Each accepted descriptor adds 1 to the write counter (direction 1) or the read counter (direction 0), but only while count-control bit 5 is 1. While that bit is 0, both counters hold.
- R12: A doorbell with a burst count of 0 issues no descriptor and sets done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | output | 1 | Descriptor offered |
| req_ready | input | 1 | Descriptor accepted when high with `req_valid` |
| req_addr | output | 64 | Descriptor target address |
| req_len | output | 12 | Descriptor length in dwords |
| req_write | output | 1 | Descriptor direction, 1 = write |
| req_data | output | 32 | Descriptor data word |

## Verification
The bench applies irregular back-pressure while it walks runs that mix both directions and the increment and address options. The base address lies just below a 32-bit boundary, so an engine that dropped the upper carry would emit a wrong high address word. A pattern of all ones catches a data word that fails to wrap. The repeat test clears the flag in mid-burst. An engine that stopped at once, or that set done at the end of the first burst, would issue the wrong number of descriptors. A doorbell sent during that run would restart the address if it were honoured. Freezing the counters during a run shows whether counting leaks past the enable. A zero burst count shows whether the engine hangs or issues a spurious descriptor.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int REG_W  = 32;
  localparam int OFS_W  = 12;
  localparam int LEN_W  = 12;
  localparam int ADDR_W = 64;
  localparam int BCNT_W = REG_W - 1;

  localparam logic [OFS_W-1:0] OFS_TGT_LO  = 12'h000;
  localparam logic [OFS_W-1:0] OFS_TGT_HI  = 12'h004;
  localparam logic [OFS_W-1:0] OFS_BURST   = 12'h008;
  localparam logic [OFS_W-1:0] OFS_CTRL    = 12'h00C;
  localparam logic [OFS_W-1:0] OFS_PATTERN = 12'h010;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 12'h014;
  localparam logic [OFS_W-1:0] OFS_SCR0    = 12'h018;
  localparam logic [OFS_W-1:0] OFS_SCR1    = 12'h01C;
  localparam logic [OFS_W-1:0] OFS_CNTCTL  = 12'h058;
  localparam logic [OFS_W-1:0] OFS_WCNT_LO = 12'h100;
  localparam logic [OFS_W-1:0] OFS_WCNT_HI = 12'h104;
  localparam logic [OFS_W-1:0] OFS_RCNT_LO = 12'h108;
  localparam logic [OFS_W-1:0] OFS_RCNT_HI = 12'h10C;

  localparam int BIT_RING     = 0;
  localparam int BIT_DIR      = 1;
  localparam int BIT_PAT_STEP = 16;
  localparam int BIT_ADDR_FIX = 18;
  localparam int BIT_LOOP     = 31;
  localparam int BIT_CNT_EN   = 5;

  localparam logic [REG_W-1:0] CTRL_KEEP = 32'h0005_FFFE;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             write;
    logic             pat_step;
    logic             addr_step;
  } run_cfg_t;
endpackage

// File: rtl/tg_regbank.sv
module tg_regbank
  import tg_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [OFS_W-1:0]    addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  input  logic                busy,
  input  logic                done_evt,
  input  logic [CNT_W-1:0]    wcnt,
  input  logic [CNT_W-1:0]    rcnt,
  output logic                ring,
  output run_cfg_t            ring_cfg,
  output logic [ADDR_W-1:0]   tgt_addr,
  output logic [REG_W-1:0]    pattern,
  output logic [BCNT_W-1:0]   burst_n,
  output logic                loop_en,
  output logic                cnt_en
);
  localparam int HALF = CNT_W / 2;

  logic [REG_W-1:0] tgt_lo_q, tgt_hi_q, burst_q, ctrl_q, pat_q, scr0_q, scr1_q;
  logic             done_q, cnt_en_q;
  logic             ctrl_wr;

  assign ctrl_wr = wr_en && (addr == OFS_CTRL);
  assign ring    = ctrl_wr && wdata[BIT_RING] && !busy;

  assign ring_cfg.len       = wdata[LEN_W+1:2];
  assign ring_cfg.write     = wdata[BIT_DIR];
  assign ring_cfg.pat_step  = wdata[BIT_PAT_STEP];
  assign ring_cfg.addr_step = !wdata[BIT_ADDR_FIX];

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
      burst_q  <= '0;
      ctrl_q   <= '0;
      pat_q    <= '0;
      scr0_q   <= '0;
      scr1_q   <= '0;
      cnt_en_q <= 1'b1;
    end else if (wr_en) begin
      unique case (addr)
        OFS_TGT_LO:  tgt_lo_q <= wdata;
        OFS_TGT_HI:  tgt_hi_q <= wdata;
        OFS_BURST:   burst_q  <= wdata;
        OFS_CTRL:    if (!busy) ctrl_q <= wdata & CTRL_KEEP;
        OFS_PATTERN: pat_q    <= wdata;
        OFS_SCR0:    scr0_q   <= wdata;
        OFS_SCR1:    scr1_q   <= wdata;
        OFS_CNTCTL:  cnt_en_q <= wdata[BIT_CNT_EN];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      done_q <= 1'b0;
    else if (done_evt)
      done_q <= 1'b1;
    else if (wr_en && addr == OFS_STATUS)
      done_q <= done_q & wdata[0];
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_TGT_LO:  rdata = tgt_lo_q;
      OFS_TGT_HI:  rdata = tgt_hi_q;
      OFS_BURST:   rdata = burst_q;
      OFS_CTRL:    rdata = ctrl_q;
      OFS_PATTERN: rdata = pat_q;
      OFS_STATUS:  rdata = {{(REG_W-1){1'b0}}, done_q};
      OFS_SCR0:    rdata = scr0_q;
      OFS_SCR1:    rdata = scr1_q;
      OFS_CNTCTL:  rdata = {{(REG_W-1-BIT_CNT_EN){1'b0}}, cnt_en_q, {BIT_CNT_EN{1'b0}}};
      OFS_WCNT_LO: rdata = wcnt[HALF-1:0];
      OFS_WCNT_HI: rdata = wcnt[CNT_W-1:HALF];
      OFS_RCNT_LO: rdata = rcnt[HALF-1:0];
      OFS_RCNT_HI: rdata = rcnt[CNT_W-1:HALF];
      default:     rdata = '0;
    endcase
  end

  assign tgt_addr = {tgt_hi_q, tgt_lo_q};
  assign pattern  = pat_q;
  assign burst_n  = burst_q[BCNT_W-1:0];
  assign loop_en  = burst_q[BIT_LOOP];
  assign cnt_en   = cnt_en_q;
endmodule

// File: rtl/tg_engine.sv
module tg_engine
  import tg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ring,
  input  run_cfg_t            ring_cfg,
  input  logic [ADDR_W-1:0]   tgt_addr,
  input  logic [REG_W-1:0]    pattern,
  input  logic [BCNT_W-1:0]   burst_n,
  input  logic                loop_en,
  output logic                busy,
  output logic                done_evt,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [LEN_W-1:0]    req_len,
  output logic                req_write,
  output logic [REG_W-1:0]    req_data,
  output logic                run_pat_step,
  output logic                run_addr_step
);
  logic              busy_q;
  run_cfg_t          cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  data_q;
  logic [BCNT_W-1:0] left_q;
  logic              take, last, reload;
  logic [ADDR_W-1:0] stride;

  assign take   = busy_q && req_ready;
  assign last   = (left_q == BCNT_W'(1));
  assign reload = loop_en && (burst_n != '0);
  assign stride = ADDR_W'({cfg_q.len, 2'b00});

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cfg_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      left_q <= '0;
    end else if (!busy_q) begin
      if (ring && burst_n != '0) begin
        busy_q <= 1'b1;
        cfg_q  <= ring_cfg;
        addr_q <= tgt_addr;
        data_q <= pattern;
        left_q <= burst_n;
      end
    end else if (take) begin
      if (cfg_q.pat_step)  data_q <= data_q + REG_W'(1);
      if (cfg_q.addr_step) addr_q <= addr_q + stride;
      if (last) begin
        if (reload) left_q <= burst_n;
        else        busy_q <= 1'b0;
      end else begin
        left_q <= left_q - BCNT_W'(1);
      end
    end
  end

  assign done_evt      = (!busy_q && ring && burst_n == '0) || (take && last && !reload);
  assign busy          = busy_q;
  assign req_valid     = busy_q;
  assign req_addr      = addr_q;
  assign req_len       = cfg_q.len;
  assign req_write     = cfg_q.write;
  assign req_data      = data_q;
  assign run_pat_step  = cfg_q.pat_step;
  assign run_addr_step = cfg_q.addr_step;
endmodule

// File: rtl/tg_xfer_counter.sv
module tg_xfer_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bump,
  input  logic         en,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)            value <= '0;
    else if (bump && en) value <= value + W'(1);
  end
endmodule

// File: rtl/bus_traffic_gen.sv
module bus_traffic_gen
  import tg_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr_en,
  input  logic [OFS_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [LEN_W-1:0]    req_len,
  output logic                req_write,
  output logic [REG_W-1:0]    req_data
);
  localparam int NDIR = 2;

  logic              busy, done_evt, ring, loop_en, cnt_en;
  logic              run_pat_step, run_addr_step;
  run_cfg_t          ring_cfg;
  logic [ADDR_W-1:0] tgt_addr;
  logic [REG_W-1:0]  pattern;
  logic [BCNT_W-1:0] burst_n;
  logic [CNT_W-1:0]  dir_cnt [NDIR];
  logic              accepted;

  assign accepted = req_valid && req_ready;

  tg_regbank #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .done_evt(done_evt),
    .wcnt(dir_cnt[1]), .rcnt(dir_cnt[0]),
    .ring(ring), .ring_cfg(ring_cfg), .tgt_addr(tgt_addr), .pattern(pattern),
    .burst_n(burst_n), .loop_en(loop_en), .cnt_en(cnt_en)
  );

  tg_engine u_eng (
    .clk(clk), .rst(rst), .ring(ring), .ring_cfg(ring_cfg), .tgt_addr(tgt_addr),
    .pattern(pattern), .burst_n(burst_n), .loop_en(loop_en), .busy(busy),
    .done_evt(done_evt), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write), .req_data(req_data),
    .run_pat_step(run_pat_step), .run_addr_step(run_addr_step)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    tg_xfer_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst),
      .bump(accepted && (req_write == (d == 1))),
      .en(cnt_en), .value(dir_cnt[d])
    );
  end

  logic [CNT_W-1:0] wr_count, rd_count;
  assign wr_count = dir_cnt[1];
  assign rd_count = dir_cnt[0];
endmodule

// File: rtl/tg_checker.sv
module tg_checker
  import tg_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              req_write,
  input logic [REG_W-1:0]  req_data,
  input logic              run_pat_step,
  input logic              run_addr_step,
  input logic              cnt_en,
  input logic [CNT_W-1:0]  wr_count,
  input logic [CNT_W-1:0]  rd_count
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !req_valid);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data)
                                && $stable(req_len) && $stable(req_write));

  // R3
  run_shape_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && $past(req_valid) |-> req_len == $past(req_len) && req_write == $past(req_write));

  // R5
  data_step_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && run_pat_step |=> !req_valid || req_data == $past(req_data) + 32'd1);

  // R6
  addr_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !run_addr_step |=> !req_valid || req_addr == $past(req_addr));

  // R11
  wcount_step_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_write && cnt_en |=> wr_count == $past(wr_count) + 1'b1);

  // R11
  count_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(wr_count) && $stable(rd_count));
endmodule

bind bus_traffic_gen tg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_len(req_len), .req_write(req_write), .req_data(req_data),
  .run_pat_step(run_pat_step), .run_addr_step(run_addr_step), .cnt_en(cnt_en),
  .wr_count(wr_count), .rd_count(rd_count)
);

// File: tb/test_bus_traffic_gen.sv
module test_bus_traffic_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_ready = 1'b0, req_write;
  logic [63:0] req_addr;
  logic [11:0] req_len;
  logic [31:0] req_data;

  int checks = 0;
  int failures = 0;
  int tick = 0;

  localparam logic [63:0] BASE = 64'h0000_0001_FFFF_FFF0;

  // fields: pattern[54:23] len[22:11] write[10] pat_step[9] addr_fix[8] count[7:0]
  localparam int NVEC = 5;
  localparam logic [54:0] VEC [NVEC] = '{
    {32'h1000_0000, 12'd4,    1'b1, 1'b1, 1'b0, 8'd3},
    {32'hFFFF_FFFF, 12'd64,   1'b0, 1'b1, 1'b0, 8'd2},
    {32'hA5A5_0000, 12'd32,   1'b1, 1'b0, 1'b1, 8'd4},
    {32'h0000_0007, 12'd4095, 1'b0, 1'b0, 1'b0, 8'd2},
    {32'h1234_5678, 12'd1,    1'b1, 1'b1, 1'b1, 8'd1}
  };

  bus_traffic_gen i_bus_traffic_gen (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .req_write(req_write), .req_data(req_data)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, {32'h0, v}, {32'h0, exp});
  endtask

  // one accepted descriptor, ready held high
  task automatic take(input string req, input logic [63:0] ea, input logic [11:0] el,
                      input logic ew, input logic [31:0] ed);
    req_ready = 1'b1; #1;
    check({req, " valid"}, {63'h0, req_valid}, 64'h1);
    check({req, " addr"}, req_addr, ea);
    check({req, " len"}, {52'h0, req_len}, {52'h0, el});
    check({req, " dir"}, {63'h0, req_write}, {63'h0, ew});
    check({req, " data"}, {32'h0, req_data}, {32'h0, ed});
    @(posedge clk); @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic ring(input logic [11:0] len, input logic w, input logic ps, input logic af);
    logic [31:0] c;
    c = 32'h1 | (32'(len) << 2) | (32'(w) << 1) | (32'(ps) << 16) | (32'(af) << 18);
    wr(12'h00C, c);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 valid", {63'h0, req_valid}, 64'h0);
    rd_check("R1 status", 12'h014, 32'h0);
    rd_check("R1 ctrl", 12'h00C, 32'h0);
    rd_check("R1 burst", 12'h008, 32'h0);
    rd_check("R1 cntctl", 12'h058, 32'h20);
    rd_check("R1 wcnt", 12'h100, 32'h0);
    rd_check("R1 rcnt", 12'h108, 32'h0);

    // R2 register map
    wr(12'h000, BASE[31:0]);
    wr(12'h004, BASE[63:32]);
    wr(12'h018, 32'hDEAD_0001);
    wr(12'h01C, 32'hBEEF_0002);
    wr(12'h020, 32'h5555_5555);
    rd_check("R2 tgt lo", 12'h000, BASE[31:0]);
    rd_check("R2 tgt hi", 12'h004, BASE[63:32]);
    rd_check("R2 scr0", 12'h018, 32'hDEAD_0001);
    rd_check("R2 scr1", 12'h01C, 32'hBEEF_0002);
    rd_check("R2 unmapped", 12'h020, 32'h0);
    wr(12'h018, 32'h0);
    wr(12'h01C, 32'h0);

    // vector table: R3 R5 R6 R7 R10 with back-pressure R4
    for (int k = 0; k < NVEC; k++) begin
      logic [31:0] pat;
      logic [11:0] len;
      logic        w, ps, af;
      int          n;
      pat = VEC[k][54:23]; len = VEC[k][22:11]; w = VEC[k][10];
      ps = VEC[k][9]; af = VEC[k][8]; n = int'(VEC[k][7:0]);
      wr(12'h014, 32'h0);
      rd_check("R10 done cleared", 12'h014, 32'h0);
      wr(12'h010, pat);
      wr(12'h008, 32'(n));
      ring(len, w, ps, af);
      rd_check("R3 doorbell reads 0", 12'h00C, ((32'(len) << 2) | (32'(w) << 1) | (32'(ps) << 16) | (32'(af) << 18)));
      for (int i = 0; i < n; i++) begin
        logic [63:0] ea;
        logic [31:0] ed;
        ea = BASE + (af ? 64'h0 : 64'(i) * 64'(len) * 64'd4);
        ed = pat + (ps ? 32'(i) : 32'h0);
        for (int s = 0; s < (k + i) % 3; s++) begin
          tick++;
          @(posedge clk); @(negedge clk);
        end
        take("R3 R5 R6 vec", ea, len, w, ed);
      end
      check("R7 valid after burst", {63'h0, req_valid}, 64'h0);
      rd_check("R7 done set", 12'h014, 32'h1);
      wr(12'h014, 32'h1);
      rd_check("R10 write 1 keeps done", 12'h014, 32'h1);
    end
    rd_check("R11 wcnt lo", 12'h100, 32'd8);
    rd_check("R11 rcnt lo", 12'h108, 32'd4);
    rd_check("R11 rcnt hi", 12'h10C, 32'd0);

    // R8 repeat, with R9 doorbell while busy
    wr(12'h014, 32'h0);
    wr(12'h010, 32'h100);
    wr(12'h008, 32'h8000_0003);
    ring(12'd8, 1'b1, 1'b1, 1'b0);
    take("R8 rep0", BASE,       12'd8, 1'b1, 32'h100);
    take("R8 rep1", BASE + 32,  12'd8, 1'b1, 32'h101);
    wr(12'h00C, 32'h0000_0043);
    rd_check("R9 ctrl unchanged", 12'h00C, 32'h0001_0022);
    take("R9 rep2", BASE + 64,  12'd8, 1'b1, 32'h102);
    rd_check("R8 no done at pass end", 12'h014, 32'h0);
    take("R8 rep3", BASE + 96,  12'd8, 1'b1, 32'h103);
    wr(12'h008, 32'h0000_0003);
    take("R8 rep4", BASE + 128, 12'd8, 1'b1, 32'h104);
    take("R8 rep5", BASE + 160, 12'd8, 1'b1, 32'h105);
    check("R8 stopped", {63'h0, req_valid}, 64'h0);
    rd_check("R8 done", 12'h014, 32'h1);
    rd_check("R11 wcnt after repeat", 12'h100, 32'd14);

    // R11 freeze
    wr(12'h058, 32'h0);
    wr(12'h008, 32'd2);
    ring(12'd4, 1'b1, 1'b0, 1'b1);
    take("R11 frozen a", BASE, 12'd4, 1'b1, 32'h100);
    take("R11 frozen b", BASE, 12'd4, 1'b1, 32'h100);
    rd_check("R11 frozen wcnt", 12'h100, 32'd14);
    rd_check("R11 frozen wcnt hi", 12'h104, 32'd0);
    wr(12'h058, 32'h20);
    wr(12'h008, 32'd1);
    ring(12'd4, 1'b1, 1'b0, 1'b1);
    take("R11 resumed", BASE, 12'd4, 1'b1, 32'h100);
    rd_check("R11 resumed wcnt", 12'h100, 32'd15);

    // R12 zero count
    wr(12'h014, 32'h0);
    wr(12'h008, 32'd0);
    ring(12'd4, 1'b0, 1'b0, 1'b0);
    check("R12 no descriptor", {63'h0, req_valid}, 64'h0);
    rd_check("R12 done", 12'h014, 32'h1);
    rd_check("R12 rcnt same", 12'h108, 32'd4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule